// File: doc/BRIEF.md
# Compressed Branch Target Unit

This unit resolves where control goes next for the branch forms of a 16-bit compressed instruction set. Each request gives the branch form, the raw displacement field, a 4-bit condition with the N, Z, C and V flags, the pipeline-advanced program counter (current instruction address plus 4), the current link register and, for the exchange form, a register value. One clock later the unit presents a new PC with a take strobe, a link-register value with a write enable, and an instruction-set mode bit with its own write enable.

A long call with link is split over two consecutive half-instructions. The first half stores a partial target in the link register. The second half adds its own offset to that partial target to give the final PC, and replaces the link register with the return address, which has bit 0 set. Fetch redirection and pipeline flush belong to the surrounding core.

Top module: `cbr_target_unit`

## Requirements
- R1: While `rst_n` is low, and on the first edge after reset, `pc_take`, `lr_we` and `mode_we` are low and `pc_next`, `lr_wdata` and `mode_bit` are zero.
- R2: Results appear on the clock edge that samples `req_valid` high. An edge that samples `req_valid` low leaves all three strobes low.
- R3: Near branch (`br_kind` = 0): `pc_take` is high and `pc_next` = `pc_cur` + sign-extended `disp` × 2.
- R4: Conditional branch (`br_kind` = 1): the offset is `disp[7:0]`, read as signed, × 2. The branch is taken only when the condition holds. A branch that is not taken raises no strobe.
- R5: Condition codes, with `nzcv` = {N,Z,C,V} from bit 3 down to bit 0: 0 Z; 1 !Z; 2 C; 3 !C; 4 N; 5 !N; 6 V; 7 !V; 8 C&!Z; 9 !C|Z; 10 N==V; 11 N!=V; 12 !Z&(N==V); 13 Z|(N!=V); 14 always true; 15 never true.
- R6: Long-call first half (`br_kind` = 2): `lr_we` is high, `lr_wdata` = `pc_cur` + (sign-extended `disp` × 2 shifted left by 11), and `pc_take` is low.
- R7: Long-call second half (`br_kind` = 3): `pc_next` = `link_cur` + zero-extended `disp` × 2 with `pc_take` high, and `lr_wdata` = (`pc_cur` − 2) OR 1 with `lr_we` high.
- R8: Exchange (`br_kind` = 4): `pc_take` is high and `pc_next` = `xreg` with bit 0 cleared. `mode_we` is high and `mode_bit` = `xreg[0]`. `lr_we` is low.
- R9: `br_kind` values 5 to 7 raise no strobe. `mode_we` is raised only for the exchange form.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A branch request is present |
| br_kind | input | 3 | Branch form: 0 near, 1 conditional, 2 long first half, 3 long second half, 4 exchange |
| disp | input | 11 | Raw displacement field |
| cond | input | 4 | Condition code |
| nzcv | input | 4 | Flags {N,Z,C,V} |
| pc_cur | input | 32 | Pipeline-advanced program counter |
| link_cur | input | 32 | Current link register |
| xreg | input | 32 | Register value for the exchange form |
| pc_take | output | 1 | PC write strobe |
| pc_next | output | 32 | New PC |
| lr_we | output | 1 | Link-register write enable |
| lr_wdata | output | 32 | Link-register write value |
| mode_we | output | 1 | Mode-bit write enable |
| mode_bit | output | 1 | New instruction-set mode bit |

## Verification
The assertions check, on every cycle, the rules that depend only on strobes and bit positions. Idle requests and unused forms raise no strobe. An exchange always drives an even PC. A completed long call always returns an odd link value. A first half never moves the PC. Conditions 14 and 15 always and never branch. The arithmetic cannot be checked that way: sign extension at the most negative and most positive displacements, the 11-bit shift of the first half, the return address of the second half, and the full condition table over every flag pattern. The bench checks these against its own model, using directed corner cases and seeded random requests.

// File: rtl/cbr_target_unit.sv
module cbr_target_unit #(
  parameter int AW  = 32,
  parameter int DW  = 11,
  parameter int CDW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    br_kind,
  input  logic [DW-1:0] disp,
  input  logic [3:0]    cond,
  input  logic [3:0]    nzcv,
  input  logic [AW-1:0] pc_cur,
  input  logic [AW-1:0] link_cur,
  input  logic [AW-1:0] xreg,
  output logic          pc_take,
  output logic [AW-1:0] pc_next,
  output logic          lr_we,
  output logic [AW-1:0] lr_wdata,
  output logic          mode_we,
  output logic          mode_bit
);
  localparam logic [2:0] K_NEAR = 3'd0;
  localparam logic [2:0] K_COND = 3'd1;
  localparam logic [2:0] K_LHI  = 3'd2;
  localparam logic [2:0] K_LLO  = 3'd3;
  localparam logic [2:0] K_EXCH = 3'd4;
  localparam int         HI_SH  = DW + 1;

  logic [AW-1:0] sx_long, sx_cond, zx_long;
  assign sx_long = {{(AW-DW){disp[DW-1]}}, disp};
  assign sx_cond = {{(AW-CDW){disp[CDW-1]}}, disp[CDW-1:0]};
  assign zx_long = {{(AW-DW){1'b0}}, disp};

  logic fn, fz, fc, fv, cond_ok;
  assign {fn, fz, fc, fv} = nzcv;

  always_comb begin
    case (cond)
      4'd0:    cond_ok = fz;
      4'd1:    cond_ok = !fz;
      4'd2:    cond_ok = fc;
      4'd3:    cond_ok = !fc;
      4'd4:    cond_ok = fn;
      4'd5:    cond_ok = !fn;
      4'd6:    cond_ok = fv;
      4'd7:    cond_ok = !fv;
      4'd8:    cond_ok = fc && !fz;
      4'd9:    cond_ok = !fc || fz;
      4'd10:   cond_ok = fn == fv;
      4'd11:   cond_ok = fn != fv;
      4'd12:   cond_ok = !fz && (fn == fv);
      4'd13:   cond_ok = fz || (fn != fv);
      4'd14:   cond_ok = 1'b1;
      default: cond_ok = 1'b0;
    endcase
  end

  logic          nx_take, nx_lwe, nx_mwe, nx_mbit;
  logic [AW-1:0] nx_pc, nx_lr;

  always_comb begin
    nx_take = 1'b0;
    nx_lwe  = 1'b0;
    nx_mwe  = 1'b0;
    nx_pc   = pc_next;
    nx_lr   = lr_wdata;
    nx_mbit = mode_bit;
    if (req_valid) begin
      case (br_kind)
        K_NEAR: begin
          nx_take = 1'b1;
          nx_pc   = pc_cur + (sx_long << 1);
        end
        K_COND: if (cond_ok) begin
          nx_take = 1'b1;
          nx_pc   = pc_cur + (sx_cond << 1);
        end
        K_LHI: begin
          nx_lwe = 1'b1;
          nx_lr  = pc_cur + (sx_long << HI_SH);
        end
        K_LLO: begin
          nx_take = 1'b1;
          nx_pc   = link_cur + (zx_long << 1);
          nx_lwe  = 1'b1;
          nx_lr   = (pc_cur - AW'(2)) | AW'(1);
        end
        K_EXCH: begin
          nx_take = 1'b1;
          nx_pc   = {xreg[AW-1:1], 1'b0};
          nx_mwe  = 1'b1;
          nx_mbit = xreg[0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_take  <= 1'b0;
      pc_next  <= '0;
      lr_we    <= 1'b0;
      lr_wdata <= '0;
      mode_we  <= 1'b0;
      mode_bit <= 1'b0;
    end else begin
      pc_take  <= nx_take;
      pc_next  <= nx_pc;
      lr_we    <= nx_lwe;
      lr_wdata <= nx_lr;
      mode_we  <= nx_mwe;
      mode_bit <= nx_mbit;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_valid) |-> !pc_take && !lr_we && !mode_we); // R2
  AST_UNUSED_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && br_kind > K_EXCH) |-> !pc_take && !lr_we && !mode_we); // R9
  AST_LHI_NO_PC: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && br_kind == K_LHI) |-> lr_we && !pc_take); // R6
  AST_LINK_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    (lr_we && pc_take) |-> lr_wdata[0]); // R7
  AST_EXCH_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we |-> pc_take && !pc_next[0] && !lr_we); // R8
  AST_COND_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && br_kind == K_COND && cond == 4'd15) |-> !pc_take); // R5
  AST_COND_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && br_kind == K_COND && cond == 4'd14) |-> pc_take); // R4
endmodule

// File: tb/cbr_target_unit_tb.sv
`timescale 1ns/1ps
module cbr_target_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  br_kind = '0;
  logic [10:0] disp = '0;
  logic [3:0]  cond = '0, nzcv = '0;
  logic [31:0] pc_cur = '0, link_cur = '0, xreg = '0;
  logic        pc_take, lr_we, mode_we, mode_bit;
  logic [31:0] pc_next, lr_wdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  cbr_target_unit dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .br_kind(br_kind),
    .disp(disp), .cond(cond), .nzcv(nzcv), .pc_cur(pc_cur),
    .link_cur(link_cur), .xreg(xreg), .pc_take(pc_take), .pc_next(pc_next),
    .lr_we(lr_we), .lr_wdata(lr_wdata), .mode_we(mode_we), .mode_bit(mode_bit));

  function automatic bit cond_holds(input logic [3:0] c, input logic [3:0] f);
    bit n = f[3], z = f[2], cy = f[1], v = f[0];
    bit r;
    case (c[3:1])
      3'd0: r = z;
      3'd1: r = cy;
      3'd2: r = n;
      3'd3: r = v;
      3'd4: r = cy & ~z;
      3'd5: r = ~(n ^ v);
      3'd6: r = ~z & ~(n ^ v);
      default: r = 1'b1;
    endcase
    if (c == 4'd15) return 1'b0;
    return (c == 4'd14) ? 1'b1 : (c[0] ? ~r : r);
  endfunction

  function automatic void model(output bit e_take, output logic [31:0] e_pc,
                                output bit e_lwe, output logic [31:0] e_lr,
                                output bit e_mwe, output bit e_mbit);
    int signed s11 = $signed(disp);
    int signed s8  = $signed(disp[7:0]);
    e_take = 0; e_lwe = 0; e_mwe = 0; e_pc = '0; e_lr = '0; e_mbit = 0;
    if (!req_valid) return;
    case (br_kind)
      3'd0: begin e_take = 1; e_pc = pc_cur + 32'(s11 * 2); end
      3'd1: if (cond_holds(cond, nzcv)) begin e_take = 1; e_pc = pc_cur + 32'(s8 * 2); end
      3'd2: begin e_lwe = 1; e_lr = pc_cur + 32'(s11 * 4096); end
      3'd3: begin
        e_take = 1; e_pc = link_cur + 32'(disp) * 2;
        e_lwe = 1; e_lr = (pc_cur - 32'd2) | 32'd1;
      end
      3'd4: begin e_take = 1; e_pc = xreg & ~32'd1; e_mwe = 1; e_mbit = xreg[0]; end
      default: ;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [2:0] k);
    case (k)
      3'd0: return "R3";
      3'd1: return "R4/R5";
      3'd2: return "R6";
      3'd3: return "R7";
      3'd4: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic apply(input bit v, input logic [2:0] k, input logic [10:0] d,
                       input logic [3:0] c, input logic [3:0] f,
                       input logic [31:0] pc, input logic [31:0] lk, input logic [31:0] x);
    bit et, el, em, eb;
    logic [31:0] ep, er;
    string t;
    @(negedge clk);
    req_valid = v; br_kind = k; disp = d; cond = c; nzcv = f;
    pc_cur = pc; link_cur = lk; xreg = x;
    model(et, ep, el, er, em, eb);
    t = v ? tag_of(k) : "R2";
    @(posedge clk); #1;
    chk({t, " pc_take"}, 32'(pc_take), 32'(et));
    chk({t, " lr_we"}, 32'(lr_we), 32'(el));
    chk({t, " mode_we"}, 32'(mode_we), 32'(em));
    if (et) chk({t, " pc_next"}, pc_next, ep);
    if (el) chk({t, " lr_wdata"}, lr_wdata, er);
    if (em) chk({t, " mode_bit"}, 32'(mode_bit), 32'(eb));
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 pc_take", 32'(pc_take), 0);
    chk("R1 lr_we", 32'(lr_we), 0);
    chk("R1 mode_we", 32'(mode_we), 0);
    chk("R1 pc_next", pc_next, 0);
    chk("R1 lr_wdata", lr_wdata, 0);
    chk("R1 mode_bit", 32'(mode_bit), 0);
    @(negedge clk); rst_n = 1'b1;
    // R3 extremes of the signed field
    apply(1, 3'd0, 11'h400, 0, 0, 32'h0000_1004, 0, 0);
    apply(1, 3'd0, 11'h3FF, 0, 0, 32'h0000_1004, 0, 0);
    apply(0, 3'd0, 11'h3FF, 0, 0, 32'h0000_1004, 0, 0);  // R2 idle
    // R4 R5 every condition against every flag pattern
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 16; f++)
        apply(1, 3'd1, {3'b101, 8'h80 + 8'(f)}, 4'(c), 4'(f), 32'h0800_0100, 0, 0);
    // R6 R7 a long call pair, negative then positive
    apply(1, 3'd2, 11'h7FF, 0, 0, 32'h0800_2004, 0, 0);
    apply(1, 3'd3, 11'h7FF, 0, 0, 32'h0800_2006, lr_wdata, 0);
    apply(1, 3'd2, 11'h3FF, 0, 0, 32'h0000_0004, 0, 0);
    apply(1, 3'd3, 11'h000, 0, 0, 32'h0000_0006, lr_wdata, 0);
    // R8 odd and even targets
    apply(1, 3'd4, 0, 0, 0, 32'h10, 0, 32'h0800_0101);
    apply(1, 3'd4, 0, 0, 0, 32'h10, 0, 32'hFFFF_FFFE);
    // R9 unused forms
    for (int k = 5; k < 8; k++) apply(1, 3'(k), 11'h155, 4'd14, 4'hF, 32'h40, 32'h80, 32'h3);
    for (int i = 0; i < 3000; i++)
      apply(($urandom % 8) != 0, 3'($urandom % 8), 11'($urandom), 4'($urandom),
            4'($urandom), $urandom, $urandom, $urandom);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule